// File: doc/BRIEF.md
# Three-Step Dial Combination Lock Controller

This block is a synchronous controller for a rotary combination lock. A dial front end, outside this block, reports each completed dial action as a single event. An event carries a turn direction (right or left) and a dial position from 0 to 39, and is marked by a one-cycle valid strobe. The controller opens the lock only after three correct settings arrive in a fixed order: right to 13, then left to 22, then right to 3. Getting the right values in the wrong order does not open it.

Progress through the sequence is held in a two-bit Moore state register. The four states are: idle, first step done, second step done, and open. The open output is decoded from the state alone. Once open, the lock stays open until a relock pulse returns it to idle. The combination, the dial range and the position width are parameters. They are checked at elaboration. A parameter also selects whether the open output is decoded from the state or held in its own flop loaded from the next state.

Top module: `lock_dial_ctrl`

## Requirements
- R1: A synchronous reset forces the state to idle (code 00) with the open output low. The state is visible on the state output with idle=00, first-step=01, second-step=10, open=11.
- R2: The state changes only at a rising clock edge, from the current state and the inputs sampled at that edge. The direction input is 1 for right and 0 for left.
- R3: The event sequence right-13, left-22, right-3 advances idle to 01, 01 to 10 and 10 to open. The open output is high in the cycle after the edge that sampled the third event.
- R4: A cycle with the valid strobe low and no relock leaves the state unchanged.
- R5: In idle, first-step or second-step, a valid event that is not the next expected step and is not right-13 returns the state to idle.
- R6: In first-step or second-step, a valid right-13 event that is not the expected step moves the state to first-step (01).
- R7: The open output is high exactly when the state is open (11), and never in any other state.
- R8: In the open state, valid events of any kind leave the state open.
- R9: In the open state, a relock pulse returns the state to idle. It does so even when a valid event is sampled at the same edge.
- R10: Outside the open state, relock has no effect: the state follows the event rules as if relock were low.
- R11: A valid event with a position above 39 never matches any step, so outside the open state it returns the state to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | One-cycle strobe marking a dial event |
| dir_i | input | 1 | Turn direction of the event: 1 right, 0 left |
| pos_i | input | 6 | Dial position of the event |
| relock_i | input | 1 | Returns an open lock to idle |
| state_o | output | 2 | Current progress state code |
| open_o | output | 1 | Lock open indication (Moore output) |

## Verification
Relock and dial events can arrive in the same cycle, and their meaning depends on the state. In the open state relock must win over any event. In the other states relock must be invisible, so a correct step still advances and a wrong one still restarts. Directed cases drive both inputs together at the same edge, once in the open state and once in the first-step state. The random phase also asserts relock on about one cycle in eight, independently of the event strobe, so coincidences occur in every state. Each cycle's state and open output are compared against a bench model that gives relock priority only when the model's state is open.

// File: rtl/lock_pkg.sv
package lock_pkg;

   // Progress codes; the numeric order is the order of the sequence
   typedef enum logic [1:0] {
      ST_IDLE  = 2'b00,
      ST_STEP1 = 2'b01,
      ST_STEP2 = 2'b10,
      ST_OPEN  = 2'b11
   } lock_state_t;

   localparam int unsigned NUM_STEPS = 3;

   localparam logic DIR_LEFT  = 1'b0;
   localparam logic DIR_RIGHT = 1'b1;

endpackage

// File: rtl/lock_step_match.sv
// Compares one dial event against one programmed step of the combination
module lock_step_match #(
   parameter int unsigned POS_W   = 6,
   parameter int unsigned POS_MAX = 39
) (
   input  logic             ev_dir,
   input  logic [POS_W-1:0] ev_pos,
   input  logic             key_dir,
   input  logic [POS_W-1:0] key_pos,
   output logic             hit
);

   localparam logic [POS_W-1:0] POS_LIMIT = POS_W'(POS_MAX);

   logic in_range;
   logic dir_ok;
   logic pos_ok;

   assign in_range = (ev_pos <= POS_LIMIT);
   assign dir_ok   = (ev_dir == key_dir);
   assign pos_ok   = (ev_pos == key_pos);
   assign hit      = in_range & dir_ok & pos_ok;

endmodule

// File: rtl/lock_next_state.sv
// Next-state function of the four-state progress machine
module lock_next_state
   import lock_pkg::*;
#(
   parameter int unsigned STEPS = NUM_STEPS
) (
   input  lock_state_t      cur,
   input  logic             valid,
   input  logic             relock,
   input  logic [STEPS-1:0] step_hit,
   output lock_state_t      nxt
);

   // Pad the hit vector so the state code can index it directly
   logic [3:0] hit_by_state;
   logic       expect_hit;
   logic       restart_hit;

   assign hit_by_state = {1'b0, step_hit};
   assign expect_hit   = hit_by_state[cur];
   assign restart_hit  = step_hit[0];

   always_comb begin
      nxt = cur;
      if (cur == ST_OPEN) begin
         if (relock) begin
            nxt = ST_IDLE;
         end
      end else if (valid) begin
         if (expect_hit) begin
            nxt = lock_state_t'(cur + 2'd1);
         end else if (restart_hit) begin
            nxt = ST_STEP1;
         end else begin
            nxt = ST_IDLE;
         end
      end
   end

endmodule

// File: rtl/lock_state_reg.sv
// Progress register with synchronous reset to idle
module lock_state_reg
   import lock_pkg::*;
(
   input  logic        clk,
   input  logic        rst,
   input  lock_state_t nxt,
   output lock_state_t cur
);

   always_ff @(posedge clk) begin
      if (rst) begin
         cur <= ST_IDLE;
      end else begin
         cur <= nxt;
      end
   end

endmodule

// File: rtl/lock_dial_ctrl.sv
// Top level: three-step dial combination lock controller
module lock_dial_ctrl
   import lock_pkg::*;
#(
   parameter int unsigned POS_W     = 6,
   parameter int unsigned POS_MAX   = 39,
   parameter int unsigned KEY0_POS  = 13,
   parameter int unsigned KEY1_POS  = 22,
   parameter int unsigned KEY2_POS  = 3,
   parameter logic [2:0]  KEY_DIRS  = 3'b101,
   parameter bit          OPEN_FLOP = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             valid_i,
   input  logic             dir_i,
   input  logic [POS_W-1:0] pos_i,
   input  logic             relock_i,
   output logic [1:0]       state_o,
   output logic             open_o
);

   localparam logic [NUM_STEPS*POS_W-1:0] KEY_POS_PACK = {
      POS_W'(KEY2_POS), POS_W'(KEY1_POS), POS_W'(KEY0_POS)
   };

   // Elaboration-time parameter checks
   if (POS_W < 1 || POS_W > 16) begin : g_bad_width
      $error("lock_dial_ctrl: POS_W out of supported range");
   end
   if (POS_MAX >= (1 << POS_W)) begin : g_bad_range
      $error("lock_dial_ctrl: POS_MAX does not fit in POS_W bits");
   end
   if (KEY0_POS > POS_MAX || KEY1_POS > POS_MAX || KEY2_POS > POS_MAX) begin : g_bad_key
      $error("lock_dial_ctrl: a combination position exceeds POS_MAX");
   end

   logic [NUM_STEPS-1:0] step_hit;
   lock_state_t          cur_state;
   lock_state_t          nxt_state;

   for (genvar s = 0; s < NUM_STEPS; s++) begin : g_step
      lock_step_match #(
         .POS_W  (POS_W),
         .POS_MAX(POS_MAX)
      ) u_match (
         .ev_dir (dir_i),
         .ev_pos (pos_i),
         .key_dir(KEY_DIRS[s]),
         .key_pos(KEY_POS_PACK[s*POS_W +: POS_W]),
         .hit    (step_hit[s])
      );
   end

   lock_next_state #(
      .STEPS(NUM_STEPS)
   ) u_next (
      .cur     (cur_state),
      .valid   (valid_i),
      .relock  (relock_i),
      .step_hit(step_hit),
      .nxt     (nxt_state)
   );

   lock_state_reg u_state (
      .clk(clk),
      .rst(rst),
      .nxt(nxt_state),
      .cur(cur_state)
   );

   assign state_o = cur_state;

   // Open output: decoded from the state, or kept in its own flop
   if (OPEN_FLOP) begin : g_open_flop
      logic open_q;
      always_ff @(posedge clk) begin
         if (rst) begin
            open_q <= 1'b0;
         end else begin
            open_q <= (nxt_state == ST_OPEN);
         end
      end
      assign open_o = open_q;
   end else begin : g_open_decode
      assign open_o = (cur_state == ST_OPEN);
   end

endmodule

// File: rtl/lock_dial_chk.sv
// Property checker for lock_dial_ctrl, attached by bind
module lock_dial_chk #(
   parameter int unsigned POS_W    = 6,
   parameter int unsigned POS_MAX  = 39,
   parameter int unsigned KEY0_POS = 13,
   parameter int unsigned KEY1_POS = 22,
   parameter int unsigned KEY2_POS = 3,
   parameter logic [2:0]  KEY_DIRS = 3'b101
) (
   input logic             clk,
   input logic             rst,
   input logic             valid_i,
   input logic             dir_i,
   input logic [POS_W-1:0] pos_i,
   input logic             relock_i,
   input logic [1:0]       state_o,
   input logic             open_o
);

   logic [POS_W-1:0] want_pos;
   logic             want_dir;
   logic             step_ok;
   logic             first_ok;
   logic             is_open;

   always_comb begin
      unique case (state_o)
         2'b00:   begin want_pos = POS_W'(KEY0_POS); want_dir = KEY_DIRS[0]; end
         2'b01:   begin want_pos = POS_W'(KEY1_POS); want_dir = KEY_DIRS[1]; end
         default: begin want_pos = POS_W'(KEY2_POS); want_dir = KEY_DIRS[2]; end
      endcase
   end

   assign is_open  = (state_o == 2'b11);
   assign step_ok  = valid_i && !is_open && (dir_i == want_dir) && (pos_i == want_pos);
   assign first_ok = (dir_i == KEY_DIRS[0]) && (pos_i == POS_W'(KEY0_POS));

   assert_reset_idle_R1: assert property (@(posedge clk)
      rst |=> (state_o == 2'b00 && !open_o));

   assert_advance_R3: assert property (@(posedge clk) disable iff (rst)
      step_ok |=> (state_o == ($past(state_o) + 2'd1)));

   assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
      (!valid_i && !relock_i) |=> $stable(state_o));

   assert_mismatch_R5: assert property (@(posedge clk) disable iff (rst)
      (valid_i && !is_open && !step_ok && !first_ok) |=> (state_o == 2'b00));

   assert_restart_R6: assert property (@(posedge clk) disable iff (rst)
      (valid_i && !is_open && state_o != 2'b00 && !step_ok && first_ok) |=> (state_o == 2'b01));

   assert_open_moore_R7: assert property (@(posedge clk) disable iff (rst)
      open_o == is_open);

   assert_open_sticky_R8: assert property (@(posedge clk) disable iff (rst)
      (is_open && !relock_i) |=> is_open);

   assert_relock_R9: assert property (@(posedge clk) disable iff (rst)
      (is_open && relock_i) |=> (state_o == 2'b00));

   assert_relock_ignored_R10: assert property (@(posedge clk) disable iff (rst)
      (relock_i && !is_open && !valid_i) |=> $stable(state_o));

   assert_out_of_range_R11: assert property (@(posedge clk) disable iff (rst)
      (valid_i && !is_open && pos_i > POS_W'(POS_MAX)) |=> (state_o == 2'b00));

endmodule

bind lock_dial_ctrl lock_dial_chk #(
   .POS_W   (POS_W),
   .POS_MAX (POS_MAX),
   .KEY0_POS(KEY0_POS),
   .KEY1_POS(KEY1_POS),
   .KEY2_POS(KEY2_POS),
   .KEY_DIRS(KEY_DIRS)
) u_chk (
   .clk     (clk),
   .rst     (rst),
   .valid_i (valid_i),
   .dir_i   (dir_i),
   .pos_i   (pos_i),
   .relock_i(relock_i),
   .state_o (state_o),
   .open_o  (open_o)
);

// File: tb/tb_lock_dial_ctrl.sv
`timescale 1ns/1ps
module tb_lock_dial_ctrl;

   localparam int unsigned WATCHDOG = 100000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       valid_i = 1'b0;
   logic       dir_i = 1'b0;
   logic [5:0] pos_i = '0;
   logic       relock_i = 1'b0;
   logic [1:0] state_o;
   logic       open_o;

   int checks = 0;
   int fails  = 0;
   logic [1:0] exp_state = 2'b00;
   bit done = 1'b0;

   always #2 clk = ~clk;

   lock_dial_ctrl dut (
      .clk(clk), .rst(rst), .valid_i(valid_i), .dir_i(dir_i),
      .pos_i(pos_i), .relock_i(relock_i), .state_o(state_o), .open_o(open_o)
   );

   // Requirement model: step table right-13, left-22, right-3
   function automatic logic [1:0] model_next(input logic [1:0] s, input logic v,
                                             input logic d, input logic [5:0] p,
                                             input logic r);
      logic want_d;
      int   want_p;
      if (s == 2'b11) return r ? 2'b00 : 2'b11;
      if (!v) return s;
      case (s)
         2'b00:   begin want_d = 1'b1; want_p = 13; end
         2'b01:   begin want_d = 1'b0; want_p = 22; end
         default: begin want_d = 1'b1; want_p = 3;  end
      endcase
      if (p <= 39 && d == want_d && int'(p) == want_p) return s + 2'd1;
      if (d == 1'b1 && p == 6'd13) return 2'b01;
      return 2'b00;
   endfunction

   task automatic check(input string tag);
      checks++;
      if (state_o !== exp_state || open_o !== (exp_state == 2'b11)) begin
         fails++;
         $display("FAIL %s: state=%b open=%b expected state=%b open=%b",
                  tag, state_o, open_o, exp_state, (exp_state == 2'b11));
      end
   endtask

   // Called at a falling edge; applies one event across the next rising edge
   task automatic cyc(input logic v, input logic d, input logic [5:0] p,
                      input logic r, input string tag);
      valid_i  = v;
      dir_i    = d;
      pos_i    = p;
      relock_i = r;
      exp_state = model_next(exp_state, v, d, p, r);
      @(negedge clk);
      check(tag);
   endtask

   task automatic open_lock(input string tag);
      cyc(1, 1, 13, 0, tag);
      cyc(1, 0, 22, 0, tag);
      cyc(1, 1, 3, 0, tag);
   endtask

   initial begin
      @(negedge clk);
      @(negedge clk);
      exp_state = 2'b00;
      check("R1 reset state");
      rst = 1'b0;

      // R3: full sequence, checked after each step
      cyc(1, 1, 13, 0, "R3 step one");
      cyc(1, 0, 22, 0, "R3 step two");
      cyc(1, 1, 3, 0, "R3 open R7");
      // R8: events in the open state
      cyc(1, 0, 22, 0, "R8 wrong event while open");
      cyc(1, 1, 13, 0, "R8 right13 while open");
      // R9: relock and event together
      cyc(1, 1, 13, 1, "R9 relock with event");
      // R4: gaps between steps
      cyc(1, 1, 13, 0, "R4 setup");
      cyc(0, 0, 22, 0, "R4 gap no strobe");
      cyc(0, 1, 3, 0, "R4 gap no strobe");
      // R10: relock outside open with a correct step
      cyc(1, 0, 22, 1, "R10 relock ignored in step1");
      cyc(0, 0, 0, 1, "R10 relock alone in step2");
      // R6: right-13 in second step
      cyc(1, 1, 13, 0, "R6 restart to step1");
      // R5: wrong direction on the step value
      cyc(1, 1, 22, 0, "R5 wrong direction");
      // R11: out-of-range position aliasing 13 mod 40
      cyc(1, 1, 13, 0, "R11 setup");
      cyc(1, 1, 53, 0, "R11 position above range");
      // Order matters: correct values in wrong order (R2, R5)
      cyc(1, 1, 3, 0, "R2 third value first");
      cyc(1, 0, 22, 0, "R2 second value early");
      open_lock("R3 reopen");
      cyc(0, 0, 0, 1, "R9 relock alone");
      cyc(1, 0, 22, 0, "R5 wrong first step");

      // Constrained random phase
      void'($urandom(32'd20240611));
      for (int i = 0; i < 4000; i++) begin
         logic v, d, r;
         logic [5:0] p;
         int sel;
         v = ($urandom % 2) == 0;
         r = ($urandom % 8) == 0;
         sel = $urandom % 10;
         if (sel < 5) begin
            case (exp_state)
               2'b00:   begin d = 1; p = 13; end
               2'b01:   begin d = 0; p = 22; end
               default: begin d = 1; p = 3;  end
            endcase
         end else if (sel < 7) begin
            d = 1; p = 13;
         end else begin
            d = 1'($urandom);
            p = 6'($urandom);
         end
         cyc(v, d, p, r, "R3 R5 R6 R8 R9 R10 random");
      end

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired: cycles=%0d expected completion", WATCHDOG);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule